// File: doc/BRIEF.md
# Signed Result Window with Magnitude Extremes

This block holds a short history of signed decimal results and reports the largest and smallest of them by absolute value. Each result is a 13-bit word: a minus flag on top of three packed BCD digits. A one-cycle `store` strobe pushes the word on `result` into a four-deep window. The newest entry sits at the head and the oldest entry drops out when the window is full. A `clear` strobe empties the window.

Two separate reduction trees watch the window at all times. One picks the valid entry with the smallest magnitude and the other picks the one with the largest magnitude. The sign takes no part in either comparison. A 2-bit select then steers one of four sources to the single output: the live input word, the newest stored entry, the minimum-magnitude entry or the maximum-magnitude entry.

The window can always accept a word, so `store` is a plain strobe with no back-pressure. Every store is taken in the cycle it is raised. The output is combinational from the select, the live input and the window registers.

Top module: `rt_result_tracker`

## Requirements
- R1: A word is 13 bits wide. Bit 12 is the minus flag (1 means negative). Bits 11:8, 7:4 and 3:0 hold the hundreds, tens and units BCD digits. The magnitude is the decimal number those digits spell.
- R2: On a rising clock edge with `store`=1 and `clear`=0, `result` becomes the newest entry and every older entry moves back one place. With four entries already held, the oldest is discarded. With neither strobe raised, the window does not change.
- R3: With `sel`=1 the output is the most recently stored entry, or 0 when nothing is stored.
- R4: With `sel`=2 the output is the stored entry of smallest magnitude, with the sign ignored.
- R5: With `sel`=3 the output is the stored entry of largest magnitude, with the sign ignored.
- R6: When several stored entries share the selected magnitude, the output is the most recently stored of them, including its own sign.
- R7: With `sel`=0 the output equals `result` in the same cycle, whatever the window holds.
- R8: A rising edge with `clear`=1 empties the window. Afterwards `sel`=1, 2 and 3 all give 0 until the next store.
- R9: When `clear` and `store` are both 1 at the same edge, the clear wins and the word is not stored.
- R10: During and right after reset (`rst_n`=0) the window is empty.
- R11: The minimum and maximum consider only entries that were actually stored. With one to three entries held, the empty slots never take part in the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Empty the window at the next edge |
| store | input | 1 | Push `result` into the window at the next edge |
| result | input | 13 | Live signed BCD word |
| sel | input | 2 | Output source: 0 live, 1 newest, 2 minimum magnitude, 3 maximum magnitude |
| out_value | output | 13 | Selected signed BCD word |

## Verification
A clear and a store can meet at the same clock edge. The bench raises both strobes together, both in directed steps and during the long random run. It then reads every select position in the following cycle and expects an empty window with the word discarded. Stores and selects of the live word also fall in the same cycle. So each cycle the bench sweeps all four select values before the edge, and it judges `sel`=0 against the word being stored at that moment. Magnitudes are compared in the bench as decimal integers, and ties are resolved by a newest-first scan.

// File: rtl/rt_pkg.sv
package rt_pkg;
  typedef enum logic [1:0] {
    SEL_LIVE = 2'd0,
    SEL_LAST = 2'd1,
    SEL_MIN  = 2'd2,
    SEL_MAX  = 2'd3
  } rt_sel_e;
endpackage

// File: rtl/rt_window.sv
module rt_window #(
  parameter int W     = 13,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       store,
  input  logic [W-1:0]               din,
  output logic [DEPTH-1:0][W-1:0]    ent,
  output logic [DEPTH-1:0]           vld
);
  // Shift chain: index 0 is the newest entry.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent <= '0;
      vld <= '0;
    end else if (clear) begin
      ent <= '0;
      vld <= '0;
    end else if (store) begin
      ent <= {ent[DEPTH-2:0], din};
      vld <= {vld[DEPTH-2:0], 1'b1};
    end
  end

  p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (vld == '0));

  p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && store) |=> !vld[0]);

  p_store_head_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (store && !clear) |=> (vld[0] && ent[0] == $past(din)));

  p_store_age_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (store && !clear) |=> (ent[DEPTH-1:1] == $past(ent[DEPTH-2:0])));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!store && !clear) |=> ($stable(ent) && $stable(vld)));

  p_fill_order_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((vld & (vld + 1'b1)) == '0));
endmodule

// File: rtl/rt_extreme.sv
module rt_extreme #(
  parameter int W        = 13,
  parameter int DEPTH    = 4,
  parameter bit PICK_MAX = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DEPTH-1:0][W-1:0] ent,
  input  logic [DEPTH-1:0]        vld,
  output logic [W-1:0]            best,
  output logic                    found
);
  localparam int MAG_W = W - 1;

  // Chain from the oldest slot (DEPTH-1) toward the newest (0). A newer
  // entry replaces the running pick on equality, so the newest one wins ties.
  logic [DEPTH:0][W-1:0] stg_val;
  logic [DEPTH:0]        stg_hit;

  assign stg_val[DEPTH] = '0;
  assign stg_hit[DEPTH] = 1'b0;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic better;
    logic take;
    if (PICK_MAX) begin : g_ge
      assign better = ent[i][MAG_W-1:0] >= stg_val[i+1][MAG_W-1:0];
    end else begin : g_le
      assign better = ent[i][MAG_W-1:0] <= stg_val[i+1][MAG_W-1:0];
    end
    assign take       = vld[i] && (!stg_hit[i+1] || better);
    assign stg_val[i] = take ? ent[i] : stg_val[i+1];
    assign stg_hit[i] = take | stg_hit[i+1];

    if (PICK_MAX) begin : g_chk_max
      p_max_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vld[i] |-> (best[MAG_W-1:0] >= ent[i][MAG_W-1:0]));
    end else begin : g_chk_min
      p_min_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vld[i] |-> (best[MAG_W-1:0] <= ent[i][MAG_W-1:0]));
    end
  end

  assign best  = stg_val[0];
  assign found = stg_hit[0];

  p_none_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (vld == '0) |-> (!found && best == '0));

  p_some_found_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (vld != '0) |-> found);
endmodule

// File: rtl/rt_outsel.sv
module rt_outsel #(
  parameter int W = 13
) (
  input  logic [1:0]   sel,
  input  logic [W-1:0] live,
  input  logic [W-1:0] last,
  input  logic         last_ok,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic [W-1:0] dout
);
  import rt_pkg::*;

  rt_sel_e sel_e;
  assign sel_e = rt_sel_e'(sel);

  always_comb begin
    unique case (sel_e)
      SEL_LIVE: dout = live;
      SEL_LAST: dout = last_ok ? last : '0;
      SEL_MIN:  dout = lo;
      SEL_MAX:  dout = hi;
      default:  dout = '0;
    endcase
  end
endmodule

// File: rtl/rt_result_tracker.sv
module rt_result_tracker #(
  parameter int DIGITS = 3,
  parameter int DEPTH  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  store,
  input  logic [4*DIGITS:0]     result,
  input  logic [1:0]            sel,
  output logic [4*DIGITS:0]     out_value
);
  localparam int W = 4 * DIGITS + 1;

  logic [DEPTH-1:0][W-1:0] ent;
  logic [DEPTH-1:0]        vld;
  logic [W-1:0]            lo_val, hi_val;
  logic                    lo_ok, hi_ok;

  rt_window #(.W(W), .DEPTH(DEPTH)) u_window (
    .clk(clk), .rst_n(rst_n), .clear(clear), .store(store),
    .din(result), .ent(ent), .vld(vld)
  );

  rt_extreme #(.W(W), .DEPTH(DEPTH), .PICK_MAX(1'b0)) u_min (
    .clk(clk), .rst_n(rst_n), .ent(ent), .vld(vld),
    .best(lo_val), .found(lo_ok)
  );

  rt_extreme #(.W(W), .DEPTH(DEPTH), .PICK_MAX(1'b1)) u_max (
    .clk(clk), .rst_n(rst_n), .ent(ent), .vld(vld),
    .best(hi_val), .found(hi_ok)
  );

  rt_outsel #(.W(W)) u_outsel (
    .sel(sel), .live(result), .last(ent[0]), .last_ok(vld[0]),
    .lo(lo_val), .hi(hi_val), .dout(out_value)
  );

  p_last_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(store && !clear) && sel == 2'd1) |-> (out_value == $past(result)));

  p_min_le_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_ok && hi_ok) |-> (lo_val[W-2:0] <= hi_val[W-2:0]));

  p_extremes_agree_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lo_ok == hi_ok);
endmodule

// File: tb/tb_rt_result_tracker.sv
`timescale 1ns/10ps
module tb_rt_result_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0;
  logic        store = 1'b0;
  logic [12:0] result = '0;
  logic [1:0]  sel = '0;
  logic [12:0] out_value;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [12:0] mv [4];
  bit          mk [4];

  rt_result_tracker dut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .store(store),
    .result(result), .sel(sel), .out_value(out_value)
  );

  always #2 clk = ~clk;

  function automatic int mag(input logic [12:0] v);
    return int'(v[11:8]) * 100 + int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic [12:0] mk_word(input bit neg, input int n);
    return {neg, 4'(n / 100), 4'((n / 10) % 10), 4'(n % 10)};
  endfunction

  function automatic logic [12:0] expect_sel(input int s);
    int bi = -1;
    if (s == 0) return result;
    if (s == 1) return mk[0] ? mv[0] : 13'd0;
    for (int i = 0; i < 4; i++) begin
      if (mk[i]) begin
        if (bi < 0) bi = i;
        else if (s == 2 && mag(mv[i]) < mag(mv[bi])) bi = i;
        else if (s == 3 && mag(mv[i]) > mag(mv[bi])) bi = i;
      end
    end
    return (bi < 0) ? 13'd0 : mv[bi];
  endfunction

  task automatic check(input string tag, input logic [12:0] got, input logic [12:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // Sweep all selects before the edge, then apply the edge and update the model.
  task automatic cycle(input bit c, input bit s, input logic [12:0] v);
    string tags[4] = '{"R7", "R3", "R4/R6", "R5/R6"};
    @(negedge clk);
    clear = c; store = s; result = v;
    for (int k = 0; k < 4; k++) begin
      sel = 2'(k);
      #0.3;
      check(tags[k], out_value, expect_sel(k));
    end
    @(posedge clk);
    if (c) begin
      for (int i = 0; i < 4; i++) begin mk[i] = 1'b0; mv[i] = '0; end
    end else if (s) begin
      for (int i = 3; i > 0; i--) begin mk[i] = mk[i-1]; mv[i] = mv[i-1]; end
      mk[0] = 1'b1; mv[0] = v;
    end
  endtask

  task automatic peek(input string tag, input int s, input logic [12:0] exp);
    @(negedge clk);
    clear = 1'b0; store = 1'b0;
    sel = 2'(s);
    #0.3;
    check(tag, out_value, exp);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mk[i] = 1'b0; mv[i] = '0; end
    // R10: empty during reset
    repeat (2) @(negedge clk);
    for (int k = 1; k < 4; k++) begin
      sel = 2'(k); #0.3;
      check("R10 in reset", out_value, 13'd0);
    end
    rst_n = 1'b1;
    cycle(0, 0, mk_word(1, 123));   // R10 after reset: model empty

    // R11: single entry, min and max both it
    cycle(0, 1, mk_word(1, 42));
    peek("R11 min single", 2, mk_word(1, 42));
    peek("R11 max single", 3, mk_word(1, 42));
    // R11: zero-valued empty slots must not win min
    cycle(0, 1, mk_word(0, 300));
    peek("R11 min two", 2, mk_word(1, 42));

    // R5: sign ignored, -900 beats +100
    cycle(1, 0, '0);
    cycle(0, 1, mk_word(1, 900));
    cycle(0, 1, mk_word(0, 100));
    peek("R5 neg max", 3, mk_word(1, 900));
    peek("R4 min", 2, mk_word(0, 100));

    // R6: equal magnitude, newest wins with its sign
    cycle(1, 0, '0);
    cycle(0, 1, mk_word(1, 5));
    cycle(0, 1, mk_word(0, 5));
    peek("R6 tie min newer plus", 2, mk_word(0, 5));
    cycle(0, 1, mk_word(1, 5));
    peek("R6 tie max newer minus", 3, mk_word(1, 5));

    // R2: five stores, first (smallest) must drop out
    cycle(1, 0, '0);
    cycle(0, 1, mk_word(0, 1));
    cycle(0, 1, mk_word(0, 400));
    cycle(0, 1, mk_word(1, 250));
    cycle(0, 1, mk_word(0, 999));
    peek("R2 four held min", 2, mk_word(0, 1));
    cycle(0, 1, mk_word(1, 700));
    peek("R2 oldest dropped min", 2, mk_word(1, 250));
    peek("R2 newest", 1, mk_word(1, 700));
    peek("R2 max", 3, mk_word(0, 999));
    cycle(0, 0, mk_word(0, 7));
    peek("R2 hold", 1, mk_word(1, 700));

    // R9: clear and store together
    cycle(1, 1, mk_word(0, 77));
    peek("R9 last empty", 1, 13'd0);
    peek("R9 min empty", 2, 13'd0);
    // R8: clear after content
    cycle(0, 1, mk_word(0, 88));
    cycle(1, 0, '0);
    peek("R8 last", 1, 13'd0);
    peek("R8 max", 3, 13'd0);

    // R7: live passes regardless; R1 field positions via decimal model
    cycle(0, 0, 13'h1FFF);
    cycle(0, 1, mk_word(1, 999));

    // Near-exhaustive random run with frequent ties and collisions
    for (int t = 0; t < 3000; t++) begin
      int  n;
      bit  c, s;
      n = (t % 3 == 0) ? int'($urandom_range(0, 12)) : int'($urandom_range(0, 999));
      c = ($urandom_range(0, 19) == 0);
      s = ($urandom_range(0, 1) == 1);
      cycle(c, s, mk_word(bit'($urandom_range(0, 1)), n));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule